// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block holds the exception-related fields of a 64-bit floating-point status register. Each time a floating-point operation completes, the block receives a 5-bit vector of raised exception flags. It compares the vector against a trap-enable mask kept in the register and decides whether the operation traps.

When the operation traps, the flags are first masked by the enables and then reduced to one bit by a fixed priority. The block records that bit as the current exception, leaves the accrued field unchanged, marks the fault type as an IEEE exception and raises a trap request. When the operation does not trap, the flags replace the current field and are ORed into the accrued field, and the block pulses a strobe that tells the sequencer to advance the program counter by one instruction. A completion that raises no flags is the ordinary successful case: it clears the current field and advances.

Software can load the whole register through a write port, and that write wins over a completion in the same cycle. The arithmetic that produces the flags, and the program counter itself, are outside this block.

Top module: `fp_exc_status`

## Requirements
- R1: After reset, `status` is all zeros and `trap_req` and `pc_advance` are both 0.
- R2: When `sw_wr` is 1, `status` equals `sw_data` on the next cycle and neither `trap_req` nor `pc_advance` pulses.
- R3: When `sw_wr` and `op_done` are 1 in the same cycle, the write is applied, the completion is discarded, and neither pulse is raised.
- R4: One cycle after `op_done` (without `sw_wr`), exactly one of two one-cycle pulses appears. `trap_req` appears when `op_flags` ANDed with the enable mask in `status[27:23]` is nonzero. Otherwise `pc_advance` appears.
- R5: On a trap, the current field `status[4:0]` holds exactly one bit: the highest-priority flag among those raised and enabled. The flag positions are invalid=bit 4, overflow=bit 3, underflow=bit 2, divide-by-zero=bit 1, inexact=bit 0, and the priority order is the same.
- R6: Without a trap, the current field `status[4:0]` becomes `op_flags` exactly.
- R7: Without a trap, the accrued field `status[9:5]` becomes its old value ORed with `op_flags`. On a trap, it is unchanged.
- R8: On a trap, `status[14]` is set to 1. A completion never changes any bit outside `status[4:0]`, `status[9:5]` and `status[14]`, and a completion without a trap leaves bit 14 unchanged.
- R9: A completion with `op_flags` equal to zero clears `status[4:0]`, leaves the accrued field unchanged, and pulses `pc_advance`.
- R10: In a cycle with neither `op_done` nor `sw_wr`, `status` holds its value on the next cycle and neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_done | input | 1 | One-cycle strobe: an operation completed with `op_flags` |
| op_flags | input | 5 | Raised exceptions (invalid, overflow, underflow, div-by-zero, inexact from bit 4 to bit 0) |
| sw_wr | input | 1 | Software load of the whole status register |
| sw_data | input | 64 | Value loaded when `sw_wr` is 1 |
| status | output | 64 | Current status register contents |
| trap_req | output | 1 | One-cycle pulse: the completed operation traps |
| pc_advance | output | 1 | One-cycle pulse: no trap, advance the program counter by 4 |

## Verification
The hardest case to reach is a trap in which several enabled flags are raised together. This case exercises the priority collapse. It can only arise after software has loaded an enable mask with several bits set. The stimulus therefore loads chosen masks through the write port first. It then issues completions whose flag vectors overlap the mask in several bits, including raised-but-disabled bits that must not survive the mask. It also drives a write and a completion in the same cycle to show that the write wins.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    // Default geometry of the status register
    localparam int STATUS_W_DEF = 64;
    localparam int FLAG_W_DEF   = 5;
    localparam int CUR_LSB_DEF  = 0;
    localparam int ACC_LSB_DEF  = 5;
    localparam int FTYPE_BIT_DEF = 14;
    localparam int ENA_LSB_DEF  = 23;

    // Flag positions inside the exception vector; higher index wins a tie
    localparam int FLG_INVALID  = 4;
    localparam int FLG_OVERFLOW = 3;
    localparam int FLG_UNDERFLW = 2;
    localparam int FLG_DIVZERO  = 1;
    localparam int FLG_INEXACT  = 0;
endpackage

// File: rtl/fpx_trap_select.sv
module fpx_trap_select #(
    parameter int FLAG_W = 5
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] enables,
    output logic              trap,
    output logic [FLAG_W-1:0] final_flags
);
    logic [FLAG_W-1:0] masked;
    logic [FLAG_W-1:0] pick;
    logic              seen;

    assign masked = flags & enables;
    assign trap   = |masked;

    // Keep only the most significant surviving bit (fixed priority)
    always_comb begin
        seen = 1'b0;
        pick = '0;
        for (int k = FLAG_W - 1; k >= 0; k--) begin
            pick[k] = masked[k] & ~seen;
            seen    = seen | masked[k];
        end
    end

    assign final_flags = trap ? pick : flags;
endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge #(
    parameter int STATUS_W  = 64,
    parameter int FLAG_W    = 5,
    parameter int CUR_LSB   = 0,
    parameter int ACC_LSB   = 5,
    parameter int FTYPE_BIT = 14
) (
    input  logic [STATUS_W-1:0] cur,
    input  logic [FLAG_W-1:0]   final_flags,
    input  logic                trap,
    output logic [STATUS_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        nxt[CUR_LSB +: FLAG_W] = final_flags;
        if (trap) begin
            nxt[FTYPE_BIT] = 1'b1;
        end else begin
            nxt[ACC_LSB +: FLAG_W] = cur[ACC_LSB +: FLAG_W] | final_flags;
        end
    end
endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status #(
    parameter int STATUS_W  = fpx_pkg::STATUS_W_DEF,
    parameter int FLAG_W    = fpx_pkg::FLAG_W_DEF,
    parameter int CUR_LSB   = fpx_pkg::CUR_LSB_DEF,
    parameter int ACC_LSB   = fpx_pkg::ACC_LSB_DEF,
    parameter int FTYPE_BIT = fpx_pkg::FTYPE_BIT_DEF,
    parameter int ENA_LSB   = fpx_pkg::ENA_LSB_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_done,
    input  logic [FLAG_W-1:0]   op_flags,
    input  logic                sw_wr,
    input  logic [STATUS_W-1:0] sw_data,
    output logic [STATUS_W-1:0] status,
    output logic                trap_req,
    output logic                pc_advance
);
    typedef struct packed {
        logic [STATUS_W-1:0] reg_val;
        logic                trap;
        logic                adv;
    } state_t;

    state_t st_d, st_q;

    logic                sel_trap;
    logic [FLAG_W-1:0]   sel_flags;
    logic [STATUS_W-1:0] merged;

    fpx_trap_select #(.FLAG_W(FLAG_W)) u_sel (
        .flags       (op_flags),
        .enables     (st_q.reg_val[ENA_LSB +: FLAG_W]),
        .trap        (sel_trap),
        .final_flags (sel_flags)
    );

    fpx_status_merge #(
        .STATUS_W  (STATUS_W),
        .FLAG_W    (FLAG_W),
        .CUR_LSB   (CUR_LSB),
        .ACC_LSB   (ACC_LSB),
        .FTYPE_BIT (FTYPE_BIT)
    ) u_merge (
        .cur         (st_q.reg_val),
        .final_flags (sel_flags),
        .trap        (sel_trap),
        .nxt         (merged)
    );

    always_comb begin
        st_d       = st_q;
        st_d.trap  = 1'b0;
        st_d.adv   = 1'b0;
        if (sw_wr) begin
            st_d.reg_val = sw_data;
        end else if (op_done) begin
            st_d.reg_val = merged;
            st_d.trap    = sel_trap;
            st_d.adv     = ~sel_trap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status     = st_q.reg_val;
    assign trap_req   = st_q.trap;
    assign pc_advance = st_q.adv;
endmodule

// File: rtl/fp_exc_status_chk.sv
module fp_exc_status_chk #(
    parameter int STATUS_W  = 64,
    parameter int FLAG_W    = 5,
    parameter int CUR_LSB   = 0,
    parameter int ACC_LSB   = 5,
    parameter int FTYPE_BIT = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_done,
    input logic [FLAG_W-1:0]   op_flags,
    input logic                sw_wr,
    input logic [STATUS_W-1:0] sw_data,
    input logic [STATUS_W-1:0] status,
    input logic                trap_req,
    input logic                pc_advance
);
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && pc_advance)); // R4

    AST_DONE_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_wr) |=> (trap_req || pc_advance)); // R4

    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (status == $past(sw_data) && !trap_req && !pc_advance)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_done && !sw_wr) |=> ($stable(status) && !trap_req && !pc_advance)); // R10

    AST_TRAP_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> ($countones(status[CUR_LSB +: FLAG_W]) == 1)); // R5

    AST_TRAP_FTYPE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> status[FTYPE_BIT]); // R8

    AST_ACCRUE_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_wr) |=> (!pc_advance ||
            status[ACC_LSB +: FLAG_W] == ($past(status[ACC_LSB +: FLAG_W]) | $past(op_flags)))); // R7

    AST_TRAP_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_wr) |=> (!trap_req ||
            status[ACC_LSB +: FLAG_W] == $past(status[ACC_LSB +: FLAG_W]))); // R7
endmodule

bind fp_exc_status fp_exc_status_chk #(
    .STATUS_W  (STATUS_W),
    .FLAG_W    (FLAG_W),
    .CUR_LSB   (CUR_LSB),
    .ACC_LSB   (ACC_LSB),
    .FTYPE_BIT (FTYPE_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_done    (op_done),
    .op_flags   (op_flags),
    .sw_wr      (sw_wr),
    .sw_data    (sw_data),
    .status     (status),
    .trap_req   (trap_req),
    .pc_advance (pc_advance)
);

// File: tb/fp_exc_status_test.sv
module fp_exc_status_test;
    logic        clk;
    logic        rst_n;
    logic        op_done;
    logic [4:0]  op_flags;
    logic        sw_wr;
    logic [63:0] sw_data;
    logic [63:0] status;
    logic        trap_req;
    logic        pc_advance;

    int compared   = 0;
    int mismatched = 0;

    fp_exc_status uut (
        .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
        .sw_wr(sw_wr), .sw_data(sw_data), .status(status),
        .trap_req(trap_req), .pc_advance(pc_advance)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    localparam logic [63:0] HIGH_PAT = 64'hA5A5_0000_0000_0000;

    // Row: flags[16:12] trap[11] cur[10:6] acc[5:1] ftype[0]
    // Enable mask before the walk: invalid+overflow (5'b11000)
    localparam int NROW = 8;
    localparam logic [16:0] ROWS [NROW] = '{
        {5'b00001, 1'b0, 5'b00001, 5'b00001, 1'b0},
        {5'b00110, 1'b0, 5'b00110, 5'b00111, 1'b0},
        {5'b01000, 1'b1, 5'b01000, 5'b00111, 1'b1},
        {5'b11001, 1'b1, 5'b10000, 5'b00111, 1'b1},
        {5'b00000, 1'b0, 5'b00000, 5'b00111, 1'b1},
        {5'b10000, 1'b1, 5'b10000, 5'b00111, 1'b1},
        {5'b10110, 1'b1, 5'b10000, 5'b00111, 1'b1},
        {5'b00010, 1'b0, 5'b00010, 5'b00111, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sw_load(input logic [63:0] v);
        @(negedge clk);
        sw_wr = 1'b1; sw_data = v;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    // Completion; returns after the result cycle is visible
    task automatic complete(input logic [4:0] f);
        @(negedge clk);
        op_done = 1'b1; op_flags = f;
        @(negedge clk);
        op_done = 1'b0; op_flags = '0;
    endtask

    initial begin
        #150000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_done = 1'b0; op_flags = '0; sw_wr = 1'b0; sw_data = '0;
        repeat (3) @(negedge clk);
        check("R1 status", status, 64'h0);
        check("R1 pulses", {62'h0, trap_req, pc_advance}, 64'h0);
        rst_n = 1'b1;

        // R2: load with enables 11000 and a high pattern
        sw_load(HIGH_PAT | (64'h18 << 23));
        check("R2 load", status, HIGH_PAT | (64'h18 << 23));
        check("R2 no pulse", {62'h0, trap_req, pc_advance}, 64'h0);

        // Table walk: R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NROW; i++) begin
            complete(ROWS[i][16:12]);
            check("R4 trap", {63'h0, trap_req}, {63'h0, ROWS[i][11]});
            check("R4 advance", {63'h0, pc_advance}, {63'h0, ~ROWS[i][11]});
            check(ROWS[i][11] ? "R5 current" : "R6 R9 current", {59'h0, status[4:0]}, {59'h0, ROWS[i][10:6]});
            check("R7 accrued", {59'h0, status[9:5]}, {59'h0, ROWS[i][5:1]});
            check("R8 ftype", {63'h0, status[14]}, {63'h0, ROWS[i][0]});
            check("R8 untouched", status[63:28], HIGH_PAT[63:28]);
            check("R8 enables", {59'h0, status[27:23]}, 64'h18);
        end

        // R10: idle cycles keep everything
        @(negedge clk);
        @(negedge clk);
        check("R10 hold", status[9:0], {5'b00111, 5'b00010});
        check("R10 pulses", {62'h0, trap_req, pc_advance}, 64'h0);

        // R5: all enabled, priority ladder
        sw_load(64'h1F << 23);
        complete(5'b11111); check("R5 invalid wins", {59'h0, status[4:0]}, 64'h10);
        complete(5'b01111); check("R5 overflow wins", {59'h0, status[4:0]}, 64'h08);
        complete(5'b00111); check("R5 underflow wins", {59'h0, status[4:0]}, 64'h04);
        complete(5'b00011); check("R5 divzero wins", {59'h0, status[4:0]}, 64'h02);
        complete(5'b00001); check("R5 inexact", {59'h0, status[4:0]}, 64'h01);
        check("R7 trap keeps accrued", {59'h0, status[9:5]}, 64'h0);
        check("R8 ftype set", {63'h0, status[14]}, 64'h1);

        // R3: write and completion together; write wins, no pulse
        @(negedge clk);
        sw_wr = 1'b1; sw_data = 64'h0000_0000_0000_0123;
        op_done = 1'b1; op_flags = 5'b10000;
        @(negedge clk);
        sw_wr = 1'b0; op_done = 1'b0; op_flags = '0;
        check("R3 write wins", status, 64'h0000_0000_0000_0123);
        check("R3 no pulse", {62'h0, trap_req, pc_advance}, 64'h0);

        // R8: no-trap completion leaves bit 14 clear, R9 zero flags
        complete(5'b00000);
        check("R9 current cleared", status, 64'h0000_0000_0000_0120);
        check("R9 advance", {63'h0, pc_advance}, 64'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule